// File: doc/BRIEF.md
# Stop-Mode Recovery Delay Controller

This block keeps a five-bit system configuration register and uses it to time how the core leaves stop mode. Three register bits go straight to neighbouring blocks: power-down of the low-voltage detector, its 5 V / 3 V trip-range select, and disable of the watchdog. A fourth bit decides whether a stop request is honoured or rejected as an illegal opcode. The fifth bit requests fast recovery.

Once the core is stopped, a wake event loads a 13-bit down-counter that runs on the oscillator clock. The load value is a short 32-cycle delay or a long 4096-cycle delay. The short delay is used only when the fast-recovery bit is set, the wake is not caused by a low-voltage reset, and the clock is usable at once: either it comes from an external source, or the on-chip oscillator was kept running during stop. When the count ends, a one-cycle release pulse goes to the CPU and the block is ready for the next stop request.

Two resets are supported. Power-on reset clears everything. General reset clears everything except the trip-range bit, which keeps its value.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After power-on reset, `cfg_o` is 0 and `stopped_o`, `illegal_op_o`, `release_o`, `lvi_pwr_off_o`, `lvi_5v_mode_o` and `wdog_off_o` are all 0.
- R2: A write through `cfg_we_i` loads `cfg_wdata_i` into the register, and `cfg_o` shows it after the next edge. The bit map is: bit 0 watchdog off, bit 1 stop enable, bit 2 fast recovery, bit 3 5 V trip range, bit 4 detector powered down. Bits 0, 3 and 4 drive `wdog_off_o`, `lvi_5v_mode_o` and `lvi_pwr_off_o`.
- R3: General reset (`sys_rst_i`) clears bits 0, 1, 2 and 4 and leaves bit 3 unchanged. Power-on reset (`por_i`) clears all bits. Power-on reset wins over general reset, and both win over a write.
- R4: With bit 1 set, a stop request sampled while the block is idle makes `stopped_o` high after that edge.
- R5: With bit 1 clear, a stop request sampled while idle makes `illegal_op_o` high for exactly one cycle, and `stopped_o` stays low.
- R6: When bit 2 is set, `lvi_rst_i` is low and either `ext_clk_i` or `osc_in_stop_i` is high at the edge that samples the wake, `release_o` is high in the cycle after the 32nd rising edge that follows that edge, and low before it.
- R7: When bit 2 is clear, the same release happens after the 4096th edge.
- R8: When bit 2 is set but both `ext_clk_i` and `osc_in_stop_i` are low, the delay is 4096 edges.
- R9: When `lvi_rst_i` is high at the wake edge, the delay is 4096 edges, whatever bit 2 says.
- R10: `release_o` lasts exactly one cycle. `stopped_o` falls on the same edge that raises it.
- R11: A wake event while the counter runs does not change the release cycle. A wake event while the block is idle produces no release.
- R12: While stopped or counting, a stop request produces no `illegal_op_o` pulse and does not change the release cycle. A new stop is accepted only after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| sys_rst_i | input | 1 | General reset, synchronous, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | Configuration write data |
| stop_req_i | input | 1 | Stop request from the core |
| wake_i | input | 1 | Wake-up event |
| lvi_rst_i | input | 1 | Wake is caused by a low-voltage reset |
| osc_in_stop_i | input | 1 | On-chip oscillator kept running in stop |
| ext_clk_i | input | 1 | Clock taken from an external source |
| cfg_o | output | 5 | Register contents |
| lvi_pwr_off_o | output | 1 | Low-voltage detector powered down |
| lvi_5v_mode_o | output | 1 | Low-voltage detector in 5 V range |
| wdog_off_o | output | 1 | Watchdog disabled |
| stopped_o | output | 1 | Core is held in stop |
| illegal_op_o | output | 1 | Rejected stop, one-cycle pulse |
| release_o | output | 1 | End-of-recovery pulse to the CPU |

## Verification
The delay choice is exercised with directed wakes that flip one input at a time from a fast-recovery case: external clock alone, kept-running oscillator alone, neither, low-voltage cause, and fast recovery off. Each of these separates one term of the selection rule from the others. Random rounds draw the register bits and the three wake qualifiers together. They also inject a second wake or a stop request at a random point in the count, so that a reload or a rejected stop would move or add a release pulse. Every edge of each count is compared, which catches off-by-one errors in the load value and pulses that come early.

// File: rtl/stpwk_pkg.sv
package stpwk_pkg;
  localparam int CFG_W     = 5;
  localparam int B_WDOG    = 0;
  localparam int B_STOP_EN = 1;
  localparam int B_QUICK   = 2;
  localparam int B_HI_V    = 3;
  localparam int B_LVI_OFF = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HALT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;

  // Fast recovery needs a clock that is valid at once and a wake not caused by low voltage.
  function automatic logic quick_allowed(input logic quick, input logic ext_clk,
                                         input logic osc_on, input logic lvi_cause);
    return quick && !lvi_cause && (ext_clk || osc_on);
  endfunction

  function automatic int unsigned wake_cycles(input logic use_quick,
                                              input int unsigned short_len,
                                              input int unsigned long_len);
    return use_quick ? short_len : long_len;
  endfunction
endpackage

// File: rtl/stpwk_cfg_reg.sv
module stpwk_cfg_reg
  import stpwk_pkg::*;
(
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             sys_rst_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  localparam logic [CFG_W-1:0] KEEP_MASK = CFG_W'(1) << B_HI_V;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i) begin
    if (por_i)          cfg_q <= '0;
    else if (sys_rst_i) cfg_q <= cfg_q & KEEP_MASK;
    else if (we_i)      cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;

  // R3: the trip-range bit survives a general reset
  a_r3_keep_range: assert property (@(posedge clk_i) disable iff (por_i)
    sys_rst_i |=> cfg_q[B_HI_V] == $past(cfg_q[B_HI_V]));
  // R3: the other bits are cleared by a general reset
  a_r3_clear_rest: assert property (@(posedge clk_i) disable iff (por_i)
    sys_rst_i |=> (cfg_q & ~KEEP_MASK) == '0);
  // R1: power-on reset empties the register
  a_r1_por_clear: assert property (@(posedge clk_i)
    por_i |=> cfg_q == '0);
endmodule

// File: rtl/stpwk_count.sv
module stpwk_count #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             zero_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign zero_o = busy_q && (cnt_q == '0);
  assign cnt_o  = cnt_q;

  // R10: the count ends on its own once zero is reached
  a_r10_stop_at_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (zero_o && !load_i) |=> !busy_o);
endmodule

// File: rtl/stpwk_seq.sv
module stpwk_seq
  import stpwk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic stop_req_i,
  input  logic stop_en_i,
  input  logic wake_i,
  input  logic done_i,
  output logic load_o,
  output logic stopped_o,
  output logic illegal_o,
  output logic release_o
);
  seq_state_t state_q;
  logic       illegal_q;
  logic       release_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= ST_IDLE;
      illegal_q <= 1'b0;
      release_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      release_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (stop_req_i) begin
          if (stop_en_i) state_q   <= ST_HALT;
          else           illegal_q <= 1'b1;
        end
        ST_HALT: if (wake_i) state_q <= ST_RUN;
        ST_RUN:  if (done_i) begin
          state_q   <= ST_IDLE;
          release_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o    = (state_q == ST_HALT) && wake_i;
  assign stopped_o = (state_q != ST_IDLE);
  assign illegal_o = illegal_q;
  assign release_o = release_q;

  // R5: a rejected stop never leaves the core stopped
  a_r5_reject_not_stopped: assert property (@(posedge clk_i) disable iff (rst_i)
    illegal_o |-> !stopped_o);
  // R12: stop requests while busy are not flagged
  a_r12_busy_no_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    (stopped_o && stop_req_i) |=> !illegal_o);
  // R10: release is a single-cycle pulse
  a_r10_release_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    release_o |=> !release_o);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import stpwk_pkg::*;
#(
  parameter int CNT_W     = 13,
  parameter int SHORT_LEN = 32,
  parameter int LONG_LEN  = 4096
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             sys_rst_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             stop_req_i,
  input  logic             wake_i,
  input  logic             lvi_rst_i,
  input  logic             osc_in_stop_i,
  input  logic             ext_clk_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             lvi_pwr_off_o,
  output logic             lvi_5v_mode_o,
  output logic             wdog_off_o,
  output logic             stopped_o,
  output logic             illegal_op_o,
  output logic             release_o
);
  localparam logic [CNT_W-1:0] LONG_LOAD = CNT_W'(LONG_LEN - 1);

  logic [CFG_W-1:0] cfg;
  logic             any_rst;
  logic             short_ok;
  logic             load_evt;
  logic             cnt_busy;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] load_val;

  assign any_rst = por_i || sys_rst_i;

  stpwk_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .por_i    (por_i),
    .sys_rst_i(sys_rst_i),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .cfg_o    (cfg)
  );

  assign short_ok = quick_allowed(cfg[B_QUICK], ext_clk_i, osc_in_stop_i, lvi_rst_i);
  assign load_val = CNT_W'(wake_cycles(short_ok, SHORT_LEN, LONG_LEN) - 1);

  stpwk_seq u_seq (
    .clk_i     (clk_i),
    .rst_i     (any_rst),
    .stop_req_i(stop_req_i),
    .stop_en_i (cfg[B_STOP_EN]),
    .wake_i    (wake_i),
    .done_i    (cnt_zero),
    .load_o    (load_evt),
    .stopped_o (stopped_o),
    .illegal_o (illegal_op_o),
    .release_o (release_o)
  );

  stpwk_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_i     (any_rst),
    .load_i    (load_evt),
    .load_val_i(load_val),
    .busy_o    (cnt_busy),
    .zero_o    (cnt_zero),
    .cnt_o     (cnt_val)
  );

  assign cfg_o         = cfg;
  assign wdog_off_o    = cfg[B_WDOG];
  assign lvi_5v_mode_o = cfg[B_HI_V];
  assign lvi_pwr_off_o = cfg[B_LVI_OFF];

  // R9: a low-voltage wake always loads the long delay
  a_r9_lvi_long: assert property (@(posedge clk_i) disable iff (any_rst)
    (load_evt && lvi_rst_i) |=> cnt_val == LONG_LOAD);
  // R8: without a ready clock the long delay is loaded
  a_r8_no_clock_long: assert property (@(posedge clk_i) disable iff (any_rst)
    (load_evt && !ext_clk_i && !osc_in_stop_i) |=> cnt_val == LONG_LOAD);
  // R11: a running count only moves down, so a wake never reloads it
  a_r11_no_reload: assert property (@(posedge clk_i) disable iff (any_rst)
    (cnt_busy && !cnt_zero) |=> cnt_val < $past(cnt_val));
  // R10: release comes with the core leaving stop
  a_r10_release_exit: assert property (@(posedge clk_i) disable iff (any_rst)
    release_o |-> !stopped_o);
endmodule

// File: tb/tb_stop_wake_ctrl.sv
`timescale 1ns/1ps
module tb_stop_wake_ctrl;
  logic       clk = 1'b0;
  logic       por = 1'b1, srst = 1'b0, we = 1'b0;
  logic [4:0] wdata = '0;
  logic       stop_req = 1'b0, wake = 1'b0, lvi = 1'b0, osc = 1'b0, ext = 1'b0;
  logic [4:0] cfg;
  logic       lvi_off, hi_v, wd_off, stopped, illegal, rel;
  int         checks = 0, errors = 0;
  logic [4:0] model_cfg = '0;

  always #2 clk = ~clk;

  stop_wake_ctrl dut (
    .clk_i(clk), .por_i(por), .sys_rst_i(srst), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .stop_req_i(stop_req), .wake_i(wake), .lvi_rst_i(lvi), .osc_in_stop_i(osc),
    .ext_clk_i(ext), .cfg_o(cfg), .lvi_pwr_off_o(lvi_off), .lvi_5v_mode_o(hi_v),
    .wdog_off_o(wd_off), .stopped_o(stopped), .illegal_op_o(illegal), .release_o(rel)
  );

  function automatic int exp_delay(input logic [4:0] c, input logic e, input logic o,
                                   input logic l);
    if (l) return 4096;
    if (!c[2]) return 4096;
    if (!(e | o)) return 4096;
    return 32;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [4:0] v);
    we = 1'b1; wdata = v; tick(); we = 1'b0;
    model_cfg = v;
  endtask

  // One full stop / wake / release round; extra event injected at count edge `at`.
  task automatic round(input logic e, input logic o, input logic l, input int at,
                       input bit extra_is_stop, input string req);
    int n;
    int bad = 0;
    int where = 0;
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    chk(stopped === 1'b1, "R4 stop entry", int'(stopped), 1);
    tick();
    ext = e; osc = o; lvi = l; wake = 1'b1; tick(); wake = 1'b0;
    n = exp_delay(model_cfg, e, o, l);
    for (int k = 1; k <= n; k++) begin
      if (k == at) begin
        if (extra_is_stop) stop_req = 1'b1; else wake = 1'b1;
      end
      tick();
      stop_req = 1'b0; wake = 1'b0;
      if (rel !== (k == n) || stopped !== (k != n) || illegal !== 1'b0) begin
        if (bad == 0) where = k;
        bad++;
      end
    end
    chk(bad == 0, req, where, n);
    tick();
    chk(rel === 1'b0, "R10 release one cycle", int'(rel), 0);
    lvi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    tick(); tick(); por = 1'b0; tick();
    chk(cfg == 5'd0 && !stopped && !illegal && !rel && !lvi_off && !hi_v && !wd_off,
        "R1 reset state", int'(cfg), 0);

    write_cfg(5'b11111);
    chk(cfg == 5'b11111, "R2 readback", int'(cfg), 31);
    chk({lvi_off, hi_v, wd_off} == 3'b111, "R2 outputs", int'({lvi_off, hi_v, wd_off}), 7);
    write_cfg(5'b01001);
    chk({lvi_off, hi_v, wd_off} == 3'b011, "R2 field positions",
        int'({lvi_off, hi_v, wd_off}), 3);

    write_cfg(5'b11111);
    srst = 1'b1; we = 1'b1; wdata = 5'b10111; tick(); srst = 1'b0; we = 1'b0;
    model_cfg = 5'b01000;
    chk(cfg == 5'b01000, "R3 general reset keeps range bit", int'(cfg), 8);
    por = 1'b1; tick(); por = 1'b0;
    model_cfg = 5'b00000;
    chk(cfg == 5'b00000, "R3 power-on clears all", int'(cfg), 0);

    // R5: stop disabled
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    chk(illegal === 1'b1 && stopped === 1'b0, "R5 rejected stop", int'({illegal, stopped}), 2);
    tick();
    chk(illegal === 1'b0, "R5 pulse width", int'(illegal), 0);

    // R11: wake while idle
    write_cfg(5'b00110);
    begin
      int seen = 0;
      wake = 1'b1; ext = 1'b1; tick(); wake = 1'b0;
      for (int k = 0; k < 40; k++) begin
        tick();
        if (rel !== 1'b0 || stopped !== 1'b0) seen++;
      end
      chk(seen == 0, "R11 idle wake ignored", seen, 0);
    end

    round(1'b1, 1'b0, 1'b0, 0, 1'b0, "R6 short delay external clock");
    round(1'b0, 1'b1, 1'b0, 0, 1'b0, "R6 short delay oscillator kept on");
    round(1'b0, 1'b0, 1'b0, 0, 1'b0, "R8 no ready clock long delay");
    round(1'b1, 1'b1, 1'b1, 0, 1'b0, "R9 low-voltage wake long delay");
    round(1'b1, 1'b0, 1'b0, 10, 1'b0, "R11 wake during count");
    round(1'b1, 1'b0, 1'b0, 12, 1'b1, "R12 stop during count");
    write_cfg(5'b00010);
    round(1'b1, 1'b1, 1'b0, 0, 1'b0, "R7 fast recovery off");

    for (int i = 0; i < 12; i++) begin
      logic [4:0] c;
      logic       e, o, l;
      int         n, at;
      c = 5'($urandom) | 5'b00010;
      e = 1'($urandom); o = 1'($urandom); l = 1'($urandom_range(0, 3) == 0);
      write_cfg(c);
      n = exp_delay(c, e, o, l);
      at = $urandom_range(1, n - 2);
      round(e, o, l, at, 1'($urandom), n == 32 ? "R6 random short" : "R7 random long");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule